// File: doc/BRIEF.md
# UART Dual-Counter Bit-Rate Generator

This block produces the bit-rate ticks that pace an asynchronous serial port. A prescaler turns the system clock into a base-clock enable pulse, at one of eleven power-of-two rates. That pulse drives two separate 8-bit counters, one for the transmit side and one for the receive side. Each counter emits a one-cycle tick every time it has counted a programmable number of base-clock pulses.

The counters follow the port's controls:

- The transmit counter runs whenever power and transmit enable are both on.
- The transmit counter is zeroed by the first write to the transmit buffer. It is zeroed again at the end of a frame only if another byte is already waiting. Otherwise it keeps running on its old phase.
- The receive counter runs only from a detected start bit to the end of that frame.

The whole design runs on the system clock. The base clock is a clock-enable, not a derived clock.

Top module: `uart_brg_dual`

## Requirements
- R1: `clk_sel` codes 0 to 10 set the base-clock enable period to 2^code system cycles. Codes 11 to 15 act as code 0, which gives one base pulse per cycle.
- R2: While `pwr_en` is 0, no base pulse occurs, `tx_tick` and `rx_tick` stay 0, and both counters are held at zero. When power returns, the first transmit tick follows the full divisor.
- R3: A running counter wraps to zero after `divisor` base pulses. On the pulse that wraps it, its tick is high for exactly one system cycle. With `clk_sel` = 0, tick spacing is therefore `divisor` cycles.
- R4: A `divisor` value of 0 to 3 is treated as 4.
- R5: While `pwr_en` or `tx_en` is 0, the transmit counter is zero and `tx_tick` is 0. The transmit counter restarts from zero once both inputs are 1. With `clk_sel` = 0, its first tick appears after the `divisor`-th rising edge at which both are 1.
- R6: A `txbuf_wr` with no transfer in progress zeroes the transmit counter and marks a transfer active. With `clk_sel` = 0, `tx_tick` rises after the `divisor`-th rising edge that follows the write edge.
- R7: A `txbuf_wr` during an active transfer marks a byte as pending. A later `tx_frame_done` then zeroes the transmit counter. The next tick comes after `divisor` further edges.
- R8: A `tx_frame_done` with no byte pending does not zero the transmit counter. Counting continues on the same phase, and the transfer ends.
- R9: While `pwr_en` or `rx_en` is 0, the receive counter is zero and idle. Raising `rx_en` again does not start it.
- R10: `rx_start_det` zeroes the receive counter and starts it. With `clk_sel` = 0, `rx_tick` rises after the `divisor`-th edge after the start edge, then every `divisor` cycles.
- R11: `rx_frame_done` stops and zeroes the receive counter. No `rx_tick` occurs until the next `rx_start_det`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Port power enable; gates the base clock |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| clk_sel | input | 4 | Base-clock prescale code |
| divisor | input | 8 | Base pulses per bit |
| txbuf_wr | input | 1 | Transmit-buffer write strobe |
| tx_frame_done | input | 1 | Pulse at the end of a transmitted frame |
| rx_start_det | input | 1 | Pulse when a start bit is detected |
| rx_frame_done | input | 1 | Pulse at the end of a received frame |
| tx_tick | output | 1 | One-cycle transmit bit tick |
| rx_tick | output | 1 | One-cycle receive bit tick |

## Verification
The following properties are checked on every cycle:

- Both ticks are single-cycle pulses.
- Neither tick appears while power is off.
- Each counter is held at zero while its enables are low.
- A pending byte forces a restart at the frame boundary.
- An idle receive counter never ticks.
- A non-zero prescale code never gives back-to-back base pulses.

Only the bench scenarios can show the following:

- The exact tick spacing for each prescale code and divisor, including the reserved codes and the divisor clamp.
- The latency from a buffer write or start bit to the first tick.
- The one-edge difference between a frame end with a byte pending and one without.

// File: rtl/ubrg_pkg.sv
package ubrg_pkg;

    localparam int unsigned SEL_W   = 4;
    localparam int unsigned DIV_W   = 8;
    localparam int unsigned PRE_W   = 10;
    localparam int unsigned MIN_DIV = 4;

    // Divisor floor shared by both counters (R4)
    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
        return (d < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : d;
    endfunction

endpackage

// File: rtl/ubrg_prescale.sv
module ubrg_prescale #(
    parameter int unsigned PRE_W = ubrg_pkg::PRE_W,
    parameter int unsigned SEL_W = ubrg_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_en,
    input  logic [SEL_W-1:0] sel,
    output logic             base_en
);
    localparam int unsigned MAX_CODE = PRE_W;
    localparam int unsigned MW       = PRE_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t    s_d, s_q;
    logic [SEL_W-1:0] code;
    logic [MW-1:0]    mask;

    always_comb begin
        code    = (sel > SEL_W'(MAX_CODE)) ? '0 : sel;
        mask    = (MW'(1) << code) - MW'(1);
        base_en = pwr_en && ((s_q.cnt & mask[PRE_W-1:0]) == mask[PRE_W-1:0]);
        s_d     = s_q;
        s_d.cnt = pwr_en ? s_q.cnt + PRE_W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_base_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (code != '0 && base_en) |=> (!base_en || sel != $past(sel)))
        else $error("base pulses adjacent with non-zero prescale code");

endmodule

// File: rtl/ubrg_tx_counter.sv
module ubrg_tx_counter #(
    parameter int unsigned DIV_W = ubrg_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             base_en,
    input  logic [DIV_W-1:0] div_eff,
    input  logic             wr,
    input  logic             frame_done,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             busy;
        logic             pend;
        logic             tick;
    } tx_state_t;

    tx_state_t s_d, s_q;
    logic      wrap;
    logic      restart;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        restart  = 1'b0;
        wrap     = (s_q.cnt >= div_eff - DIV_W'(1));
        if (!run) begin
            s_d = '0;
        end else if (wr && !s_q.busy) begin
            s_d.cnt  = '0;
            s_d.busy = 1'b1;
            s_d.pend = 1'b0;
        end else begin
            if (frame_done && s_q.busy) begin
                if (s_q.pend || wr) begin
                    s_d.cnt  = '0;
                    s_d.pend = 1'b0;
                    restart  = 1'b1;
                end else begin
                    s_d.busy = 1'b0;
                end
            end else if (wr) begin
                s_d.pend = 1'b1;
            end
            if (!restart && base_en) begin
                if (wrap) begin
                    s_d.cnt  = '0;
                    s_d.tick = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + DIV_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    p_tx_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.cnt == '0 && !s_q.busy && !tick))
        else $error("tx counter not held while disabled");

    p_tx_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("tx tick longer than one cycle");

    p_tx_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && frame_done && s_q.busy && s_q.pend) |=> (s_q.cnt == '0 && !tick))
        else $error("tx counter not restarted with byte pending");

endmodule

// File: rtl/ubrg_rx_counter.sv
module ubrg_rx_counter #(
    parameter int unsigned DIV_W = ubrg_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             base_en,
    input  logic [DIV_W-1:0] div_eff,
    input  logic             start,
    input  logic             frame_done,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             active;
        logic             tick;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic      wrap;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        wrap     = (s_q.cnt >= div_eff - DIV_W'(1));
        if (!run) begin
            s_d = '0;
        end else if (start) begin
            s_d.cnt    = '0;
            s_d.active = 1'b1;
        end else if (frame_done) begin
            s_d.cnt    = '0;
            s_d.active = 1'b0;
        end else if (s_q.active && base_en) begin
            if (wrap) begin
                s_d.cnt  = '0;
                s_d.tick = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;

    p_rx_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (s_q.cnt == '0 && !s_q.active))
        else $error("rx counter not held while disabled");

    p_rx_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && frame_done && !start) |=> (!s_q.active && s_q.cnt == '0))
        else $error("rx counter still running after frame end");

    p_rx_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |=> !tick)
        else $error("rx tick while idle");

endmodule

// File: rtl/uart_brg_dual.sv
module uart_brg_dual #(
    parameter int unsigned SEL_W = ubrg_pkg::SEL_W,
    parameter int unsigned DIV_W = ubrg_pkg::DIV_W,
    parameter int unsigned PRE_W = ubrg_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_en,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [DIV_W-1:0] divisor,
    input  logic             txbuf_wr,
    input  logic             tx_frame_done,
    input  logic             rx_start_det,
    input  logic             rx_frame_done,
    output logic             tx_tick,
    output logic             rx_tick
);
    logic             base_en;
    logic [DIV_W-1:0] div_eff;
    logic             tx_run;
    logic             rx_run;

    always_comb begin
        div_eff = (divisor < DIV_W'(ubrg_pkg::MIN_DIV)) ? DIV_W'(ubrg_pkg::MIN_DIV) : divisor;
        tx_run  = pwr_en && tx_en;
        rx_run  = pwr_en && rx_en;
    end

    ubrg_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .sel(clk_sel), .base_en(base_en)
    );

    ubrg_tx_counter #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(tx_run), .base_en(base_en), .div_eff(div_eff),
        .wr(txbuf_wr), .frame_done(tx_frame_done), .tick(tx_tick)
    );

    ubrg_rx_counter #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(rx_run), .base_en(base_en), .div_eff(div_eff),
        .start(rx_start_det), .frame_done(rx_frame_done), .tick(rx_tick)
    );

    p_unpowered_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (!tx_tick && !rx_tick))
        else $error("tick while power is off");

    p_div_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |=> !tx_tick)
        else $error("tx ticks adjacent despite divisor floor");

endmodule

// File: tb/sim_uart_brg_dual.sv
module sim_uart_brg_dual;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {sel[3:0], divisor[7:0], expected spacing[15:0]}
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd0,  8'd4,   16'd4},
        {4'd0,  8'd10,  16'd10},
        {4'd1,  8'd5,   16'd10},
        {4'd3,  8'd4,   16'd32},
        {4'd2,  8'd200, 16'd800},
        {4'd10, 8'd4,   16'd4096},
        {4'd12, 8'd6,   16'd6},
        {4'd15, 8'd9,   16'd9},
        {4'd0,  8'd2,   16'd4},
        {4'd0,  8'd0,   16'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic [3:0] clk_sel = '0;
    logic [7:0] divisor = 8'd10;
    logic txbuf_wr = 1'b0, tx_frame_done = 1'b0, rx_start_det = 1'b0, rx_frame_done = 1'b0;
    logic tx_tick, rx_tick;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_brg_dual u0 (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en), .rx_en(rx_en),
        .clk_sel(clk_sel), .divisor(divisor), .txbuf_wr(txbuf_wr),
        .tx_frame_done(tx_frame_done), .rx_start_det(rx_start_det),
        .rx_frame_done(rx_frame_done), .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Edges until the chosen tick is seen high after an edge; -1 if none
    task automatic wait_tick(input bit use_rx, input int lim, output int n);
        n = 0;
        for (int i = 0; i < lim; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (use_rx ? rx_tick : tx_tick) return;
        end
        n = -1;
    endtask

    task automatic count_ticks(input int cycles, output int c);
        c = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            c += int'(tx_tick) + int'(rx_tick);
        end
    endtask

    task automatic pulse_wr();
        txbuf_wr = 1'b1; @(posedge clk); @(negedge clk); txbuf_wr = 1'b0;
    endtask

    task automatic pulse_txfd();
        tx_frame_done = 1'b1; @(posedge clk); @(negedge clk); tx_frame_done = 1'b0;
    endtask

    task automatic pulse_start();
        rx_start_det = 1'b1; @(posedge clk); @(negedge clk); rx_start_det = 1'b0;
    endtask

    task automatic pulse_rxfd();
        rx_frame_done = 1'b1; @(posedge clk); @(negedge clk); rx_frame_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int c;
        repeat (3) @(negedge clk);
        chk("R2 reset tx_tick", int'(tx_tick), 0);
        chk("R2 reset rx_tick", int'(rx_tick), 0);
        rst_n = 1'b1;

        // Spacing table: R1, R3, R4
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            pwr_en = 1'b1; tx_en = 1'b0;
            clk_sel = VEC[v][27:24]; divisor = VEC[v][23:16];
            @(negedge clk);
            tx_en = 1'b1;
            wait_tick(1'b0, 10000, n);
            wait_tick(1'b0, 10000, n);
            chk($sformatf("R1/R3/R4 spacing sel=%0d div=%0d", VEC[v][27:24], VEC[v][23:16]),
                n, int'(VEC[v][15:0]));
        end

        // R5: held while disabled, restarts from zero
        @(negedge clk);
        clk_sel = 4'd0; divisor = 8'd10; tx_en = 1'b0;
        count_ticks(40, c);
        chk("R5 no tick while tx disabled", c, 0);
        tx_en = 1'b1;
        wait_tick(1'b0, 100, n);
        chk("R5 first tick after enable", n, 10);

        // R6: first write clears
        repeat (3) @(negedge clk);
        pulse_wr();
        wait_tick(1'b0, 100, n);
        chk("R6 first write restart", n, 10);

        // R7: pending byte restarts at frame end
        repeat (2) @(negedge clk);
        pulse_wr();
        wait_tick(1'b0, 100, n);
        pulse_txfd();
        wait_tick(1'b0, 100, n);
        chk("R7 restart with pending byte", n, 10);

        // R8: no pending byte keeps phase
        pulse_txfd();
        wait_tick(1'b0, 100, n);
        chk("R8 no restart when idle", n, 9);
        wait_tick(1'b0, 100, n);
        chk("R8 free-run spacing", n, 10);

        // Receive side: R10, R11
        tx_en = 1'b0; rx_en = 1'b1;
        count_ticks(50, c);
        chk("R11 rx quiet before start", c, 0);
        pulse_start();
        wait_tick(1'b1, 100, n);
        chk("R10 first rx tick after start", n, 10);
        wait_tick(1'b1, 100, n);
        chk("R10 rx spacing", n, 10);
        pulse_rxfd();
        count_ticks(60, c);
        chk("R11 rx halted after frame", c, 0);
        pulse_start();
        wait_tick(1'b1, 100, n);
        chk("R11 rx resumes on next start", n, 10);

        // R9: disable clears activity
        rx_en = 1'b0;
        count_ticks(30, c);
        chk("R9 rx quiet while disabled", c, 0);
        rx_en = 1'b1;
        count_ticks(40, c);
        chk("R9 rx stays idle on re-enable", c, 0);

        // R2: power off silences both
        pwr_en = 1'b0; tx_en = 1'b1;
        pulse_start();
        pulse_wr();
        count_ticks(100, c);
        chk("R2 no ticks while unpowered", c, 0);
        rx_en = 1'b0;
        pwr_en = 1'b1;
        wait_tick(1'b0, 100, n);
        chk("R2 tx restarts from zero on power", n, 10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule